// File: doc/BRIEF.md
# E3 Transmit Overhead Inserter

This block sits in the byte-wide transmit path of an E3 framer built to the G.832 frame structure. Each input byte arrives with a frame-start strobe and a three-bit slot code, which says whether the byte is payload or one of the overhead octets. The block replaces the framing-alignment octets, the BIP-8 octet and the trail-trace octet with generated values. Every other byte passes through unchanged, one clock later.

A host reaches the block through a simple register bus. The trail identifier is a 16-byte set: fifteen ASCII characters in an E.164-style numbering format plus one more byte. The block sends one byte of it per frame and walks through all sixteen in turn. Three 8-bit XOR masks let test equipment corrupt FA1, FA2 and BIP-8 on purpose. A mask of all zeros leaves the octet intact. Host writes only take effect at a frame boundary, so each frame is built from one consistent set of values.

Top module: `e3_oh_inserter`

## Requirements
- R1: After reset, every register reads 0x00, out_valid_o is low, and the first frame sent carries trail byte 0.
- R2: Trail byte i is read and written at address 0x30+i, for i from 0 to 15. The FA1, FA2 and BIP-8 masks are at 0x48, 0x49 and 0x4A. Reads of any other address return 0x00, and writes to them are ignored.
- R3: A byte with slot code 1 (FA1) is sent as 0xF6 XOR the FA1 mask.
- R4: A byte with slot code 2 (FA2) is sent as 0x28 XOR the FA2 mask.
- R5: A byte with slot code 3 (BIP-8) is sent as the XOR of all bytes output since the previous frame start, up to the current frame start, XORed with the BIP-8 mask. For the first frame after reset this is the XOR of the bytes output since reset.
- R6: A byte with slot code 4 (trail trace) in frame n is sent as trail byte n mod 16. Frame n is the nth frame after reset, counted from 0.
- R7: Bytes with slot codes 0, 5, 6 and 7 are passed through unchanged.
- R8: out_valid_o, out_sof_o and out_data_o follow in_valid_i, (in_valid_i and in_sof_i) and the processed byte exactly one cycle later. in_sof_i counts only on a valid byte.
- R9: A register write takes effect from the next frame start only. A write in the same cycle as a frame start affects the frame after it.
- R10: The trail index wraps from 15 back to 0, so frames 16 and up repeat the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input byte valid |
| in_sof_i | input | 1 | First byte of a frame |
| in_slot_i | input | 3 | Slot code: 0 payload, 1 FA1, 2 FA2, 3 BIP-8, 4 trail trace, 5-7 pass-through |
| in_data_i | input | 8 | Input byte |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| out_valid_o | output | 1 | Output byte valid |
| out_sof_o | output | 1 | Output frame start |
| out_data_o | output | 8 | Output byte |

## Verification
The hardest case to reach is a host write that lands in the same cycle as a frame start, or part-way through a frame just before an overhead octet. In that case the current frame must still use the old value. The random stimulus issues writes on about one byte in four, including frame-start cycles. Frames of random length keep the overhead octets near those writes, and a directed step writes a mask on the exact frame-start cycle. More than sixteen frames are sent, so the trail index wraps more than once. The BIP-8 check relies on a running XOR kept in the bench, which covers gaps and frames of changing length.

// File: rtl/e3oh_pkg.sv
package e3oh_pkg;
  localparam int OCT_W = 8;

  typedef enum logic [2:0] {
    SLOT_PAY = 3'd0,
    SLOT_FA1 = 3'd1,
    SLOT_FA2 = 3'd2,
    SLOT_BIP = 3'd3,
    SLOT_TT  = 3'd4
  } slot_e;

  localparam logic [OCT_W-1:0] FA1_PAT = 8'hF6;
  localparam logic [OCT_W-1:0] FA2_PAT = 8'h28;

  typedef struct packed {
    logic [OCT_W-1:0] fa1;
    logic [OCT_W-1:0] fa2;
    logic [OCT_W-1:0] bip;
  } mask_t;
endpackage

// File: rtl/e3oh_regfile.sv
module e3oh_regfile
  import e3oh_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int TT_DEPTH  = 16,
  parameter int TT_BASE   = 'h30,
  parameter int MASK_BASE = 'h48,
  localparam int IDX_W    = $clog2(TT_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [OCT_W-1:0]  wdata_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [OCT_W-1:0]  rdata_o,
  output mask_t             mask_o,
  output logic [OCT_W-1:0]  tt_sel_o
);
  logic [OCT_W-1:0]    tt_q [TT_DEPTH];
  logic [TT_DEPTH-1:0] tt_we;
  logic [ADDR_W-1:0]   tt_off, mk_off;
  logic                tt_hit;
  mask_t               mask_q;

  assign tt_off = addr_i - ADDR_W'(TT_BASE);
  assign mk_off = addr_i - ADDR_W'(MASK_BASE);
  assign tt_hit = tt_off < ADDR_W'(TT_DEPTH);

  for (genvar g = 0; g < TT_DEPTH; g++) begin : g_we
    assign tt_we[g] = wr_i && tt_hit && (tt_off == ADDR_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < TT_DEPTH; i++) tt_q[i] <= '0;
    end else begin
      for (int i = 0; i < TT_DEPTH; i++)
        if (tt_we[i]) tt_q[i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
    end else if (wr_i) begin
      case (mk_off)
        ADDR_W'(0): mask_q.fa1 <= wdata_i;
        ADDR_W'(1): mask_q.fa2 <= wdata_i;
        ADDR_W'(2): mask_q.bip <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    if (tt_hit) rdata_o = tt_q[tt_off[IDX_W-1:0]];
    else begin
      case (mk_off)
        ADDR_W'(0): rdata_o = mask_q.fa1;
        ADDR_W'(1): rdata_o = mask_q.fa2;
        ADDR_W'(2): rdata_o = mask_q.bip;
        default:    rdata_o = '0;
      endcase
    end
  end

  assign mask_o   = mask_q;
  assign tt_sel_o = tt_q[rd_idx_i];
endmodule

// File: rtl/e3oh_frame_ctl.sv
module e3oh_frame_ctl
  import e3oh_pkg::*;
#(
  parameter int TT_DEPTH = 16,
  localparam int IDX_W   = $clog2(TT_DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sof_i,
  input  mask_t            mask_pend_i,
  input  logic [OCT_W-1:0] tt_pend_i,
  output mask_t            mask_eff_o,
  output logic [OCT_W-1:0] tt_eff_o,
  output logic [IDX_W-1:0] idx_o
);
  mask_t            act_mask;
  logic [OCT_W-1:0] act_tt;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_mask <= '0;
      act_tt   <= '0;
      idx_q    <= '0;
    end else if (sof_i) begin
      act_mask <= mask_pend_i;
      act_tt   <= tt_pend_i;
      idx_q    <= (idx_q == IDX_W'(TT_DEPTH-1)) ? '0 : idx_q + 1'b1;
    end
  end

  // the frame-start byte itself already belongs to the new frame
  assign mask_eff_o = sof_i ? mask_pend_i : act_mask;
  assign tt_eff_o   = sof_i ? tt_pend_i   : act_tt;
  assign idx_o      = idx_q;
endmodule

// File: rtl/e3oh_bip.sv
module e3oh_bip
  import e3oh_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sof_i,
  input  logic [OCT_W-1:0] byte_i,
  output logic [OCT_W-1:0] prev_o
);
  logic [OCT_W-1:0] acc_q, last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      last_q <= '0;
    end else if (valid_i) begin
      acc_q <= sof_i ? byte_i : (acc_q ^ byte_i);
      if (sof_i) last_q <= acc_q;
    end
  end

  assign prev_o = sof_i ? acc_q : last_q;
endmodule

// File: rtl/e3_oh_inserter.sv
module e3_oh_inserter
  import e3oh_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int TT_DEPTH  = 16,
  parameter int TT_BASE   = 'h30,
  parameter int MASK_BASE = 'h48,
  localparam int IDX_W    = $clog2(TT_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic              in_sof_i,
  input  logic [2:0]        in_slot_i,
  input  logic [OCT_W-1:0]  in_data_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [OCT_W-1:0]  reg_wdata_i,
  output logic [OCT_W-1:0]  reg_rdata_o,
  output logic              out_valid_o,
  output logic              out_sof_o,
  output logic [OCT_W-1:0]  out_data_o
);
  logic             frm_start;
  mask_t            mask_pend, mask_eff;
  logic [OCT_W-1:0] tt_pend, tt_eff, bip_prev, oct_nx;
  logic [IDX_W-1:0] tt_idx;

  assign frm_start = in_valid_i && in_sof_i;

  e3oh_regfile #(
    .ADDR_W(ADDR_W), .TT_DEPTH(TT_DEPTH), .TT_BASE(TT_BASE), .MASK_BASE(MASK_BASE)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rd_idx_i(tt_idx), .rdata_o(reg_rdata_o),
    .mask_o(mask_pend), .tt_sel_o(tt_pend)
  );

  e3oh_frame_ctl #(.TT_DEPTH(TT_DEPTH)) u_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni), .sof_i(frm_start), .mask_pend_i(mask_pend),
    .tt_pend_i(tt_pend), .mask_eff_o(mask_eff), .tt_eff_o(tt_eff), .idx_o(tt_idx)
  );

  e3oh_bip u_bip (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(in_valid_i), .sof_i(in_sof_i),
    .byte_i(oct_nx), .prev_o(bip_prev)
  );

  always_comb begin
    case (slot_e'(in_slot_i))
      SLOT_FA1: oct_nx = FA1_PAT ^ mask_eff.fa1;
      SLOT_FA2: oct_nx = FA2_PAT ^ mask_eff.fa2;
      SLOT_BIP: oct_nx = bip_prev ^ mask_eff.bip;
      SLOT_TT:  oct_nx = tt_eff;
      default:  oct_nx = in_data_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_sof_o   <= 1'b0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      out_sof_o   <= frm_start;
      if (in_valid_i) out_data_o <= oct_nx;
    end
  end
endmodule

// File: rtl/e3oh_checker.sv
module e3oh_checker #(
  parameter int TT_DEPTH = 16,
  localparam int IDX_W   = $clog2(TT_DEPTH)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_sof_i,
  input logic [2:0]       in_slot_i,
  input logic [7:0]       in_data_i,
  input logic             out_valid_o,
  input logic             out_data_dummy,
  input logic [7:0]       out_data_o,
  input logic [IDX_W-1:0] tt_idx
);
  localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(TT_DEPTH-1);

  p_quiet_in_reset_r1: assert property (@(posedge clk_i) !rst_ni |-> !out_valid_o);

  p_valid_follow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);

  p_idle_follow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);

  p_payload_pass_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_slot_i == 3'd0) |=> out_data_o == $past(in_data_i));

  p_idx_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_valid_i && in_sof_i) |=> $stable(tt_idx));

  p_idx_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_sof_i && tt_idx != IDX_MAX) |=> tt_idx == $past(tt_idx) + 1'b1);

  p_idx_wrap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_sof_i && tt_idx == IDX_MAX) |=> tt_idx == '0);
endmodule

bind e3_oh_inserter e3oh_checker #(.TT_DEPTH(TT_DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_sof_i(in_sof_i),
  .in_slot_i(in_slot_i), .in_data_i(in_data_i), .out_valid_o(out_valid_o),
  .out_data_dummy(out_sof_o), .out_data_o(out_data_o), .tt_idx(tt_idx)
);

// File: tb/e3_oh_inserter_test.sv
module e3_oh_inserter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_sof = 1'b0, reg_wr = 1'b0;
  logic [2:0] in_slot = '0;
  logic [7:0] in_data = '0, reg_addr = '0, reg_wdata = '0;
  logic [7:0] reg_rdata, out_data;
  logic       out_valid, out_sof;

  int total = 0, bad = 0;
  bit done = 0;

  // bench model
  logic [7:0] m_tt [16];
  logic [7:0] m_m1 = 0, m_m2 = 0, m_mb = 0;
  logic [7:0] a_m1 = 0, a_m2 = 0, a_mb = 0, a_tt = 0;
  logic [7:0] acc = 0, last = 0;
  int m_idx = 0, frame_cnt = 0;
  bit dirty = 0, tag9 = 0;

  always #4 clk = ~clk;

  e3_oh_inserter uut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_sof_i(in_sof),
    .in_slot_i(in_slot), .in_data_i(in_data), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .out_valid_o(out_valid),
    .out_sof_o(out_sof), .out_data_o(out_data)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit mapped(logic [7:0] a);
    return (a >= 8'h30 && a <= 8'h3F) || (a >= 8'h48 && a <= 8'h4A);
  endfunction

  function automatic logic [7:0] model_rd(logic [7:0] a);
    if (a >= 8'h30 && a <= 8'h3F) return m_tt[a - 8'h30];
    if (a == 8'h48) return m_m1;
    if (a == 8'h49) return m_m2;
    if (a == 8'h4A) return m_mb;
    return 8'h00;
  endfunction

  // one cycle; entered and left at a falling edge
  task automatic step(bit v, bit s, logic [2:0] sl, logic [7:0] d,
                      bit we, logic [7:0] wa, logic [7:0] wd);
    logic [7:0] exp, bprev;
    string tag;
    in_valid = v; in_sof = s; in_slot = sl; in_data = d;
    reg_wr = we; reg_addr = wa; reg_wdata = wd;
    exp = d; tag = "R7";
    if (v) begin
      if (s) begin
        a_m1 = m_m1; a_m2 = m_m2; a_mb = m_mb; a_tt = m_tt[m_idx];
        m_idx = (m_idx + 1) % 16;
        last = acc;
        frame_cnt++;
        tag9 = dirty; dirty = 0;
      end
      bprev = last;
      case (sl)
        3'd1: begin exp = 8'hF6 ^ a_m1; tag = tag9 ? "R9" : "R3"; end
        3'd2: begin exp = 8'h28 ^ a_m2; tag = tag9 ? "R9" : "R4"; end
        3'd3: begin exp = bprev ^ a_mb; tag = tag9 ? "R9" : "R5"; end
        3'd4: begin exp = a_tt; tag = (frame_cnt > 16) ? "R10" : (tag9 ? "R9" : "R6"); end
        default: ;
      endcase
      acc = s ? exp : (acc ^ exp);
    end
    if (we && mapped(wa)) begin
      dirty = 1;
      if (wa <= 8'h3F) m_tt[wa - 8'h30] = wd;
      else if (wa == 8'h48) m_m1 = wd;
      else if (wa == 8'h49) m_m2 = wd;
      else m_mb = wd;
    end
    @(posedge clk);
    @(negedge clk);
    reg_wr = 0;
    chk("R8 valid", {7'd0, out_valid}, {7'd0, v});
    if (v) begin
      chk("R8 sof", {7'd0, out_sof}, {7'd0, s});
      chk(tag, out_data, exp);
    end
  endtask

  task automatic rd_chk(string req, logic [7:0] a);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, model_rd(a));
  endtask

  task automatic rnd_frame(int len, bit wr_on);
    for (int i = 0; i < len; i++) begin
      logic [2:0] sl;
      bit we;
      logic [7:0] wa;
      int pick;
      case (i)
        0: sl = 3'd1; 1: sl = 3'd2; 2: sl = 3'd3; 3: sl = 3'd4;
        default: sl = ($urandom % 5 == 0) ? 3'($urandom % 8) : 3'(($urandom % 4 == 0) ? 5 + $urandom % 3 : 0);
      endcase
      pick = $urandom % 19;
      wa = (pick < 16) ? 8'(8'h30 + pick) : 8'(8'h48 + pick - 16);
      we = wr_on && ($urandom % 4 == 0);
      if (i > 0 && $urandom % 6 == 0)
        step(0, 0, 3'($urandom % 8), 8'($urandom), 0, 8'h00, 8'h00);
      step(1, i == 0, sl, 8'($urandom), we, wa, 8'($urandom));
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0E3A));
    for (int i = 0; i < 16; i++) m_tt[i] = 8'h00;
    @(negedge clk);
    chk("R1 valid in reset", {7'd0, out_valid}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset values
    for (int a = 8'h30; a <= 8'h3F; a++) rd_chk("R1", 8'(a));
    rd_chk("R1", 8'h48); rd_chk("R1", 8'h49); rd_chk("R1", 8'h4A);
    // R1/R3/R4/R5: one clean frame with zero masks
    rnd_frame(10, 0);
    // R2: program identifier and masks, read back
    for (int i = 0; i < 16; i++)
      step(0, 0, 3'd0, 8'h00, 1, 8'(8'h30 + i), (i == 15) ? 8'h00 : 8'(8'h41 + i));
    step(0, 0, 3'd0, 8'h00, 1, 8'h48, 8'h01);
    step(0, 0, 3'd0, 8'h00, 1, 8'h49, 8'h80);
    step(0, 0, 3'd0, 8'h00, 1, 8'h4A, 8'hFF);
    step(0, 0, 3'd0, 8'h00, 1, 8'h20, 8'h5A);
    step(0, 0, 3'd0, 8'h00, 1, 8'h4B, 8'hA5);
    for (int a = 8'h30; a <= 8'h3F; a++) rd_chk("R2", 8'(a));
    rd_chk("R2", 8'h48); rd_chk("R2", 8'h49); rd_chk("R2", 8'h4A);
    rd_chk("R2 unmapped", 8'h20); rd_chk("R2 unmapped", 8'h4B); rd_chk("R2 unmapped", 8'h2F);
    // R3/R4/R5/R6 with masks
    rnd_frame(12, 0);
    // R9: write FA1 mask on the frame-start cycle itself
    step(1, 1, 3'd1, 8'h00, 1, 8'h48, 8'hFF);
    step(1, 0, 3'd2, 8'h00, 1, 8'h49, 8'h00);
    step(1, 0, 3'd4, 8'h33, 1, 8'(8'h30 + m_idx), 8'hC3);
    step(1, 0, 3'd0, 8'h12, 0, 8'h00, 8'h00);
    rnd_frame(8, 0);
    // R10: many random frames with writes
    for (int f = 0; f < 60; f++) rnd_frame(6 + $urandom % 30, 1);
    for (int a = 8'h30; a <= 8'h4A; a++) rd_chk("R2", 8'(a));
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule